// File: doc/BRIEF.md
# Two-Stage Pipelined Split Adder

This block adds two unsigned operands by cutting them into narrow slices and giving each slice its own pipeline stage. The least significant slice is added in the cycle the operands arrive; its carry is captured in a flip-flop. The next slice sees that registered carry one cycle later, together with its own operand bits, which are held back by a skew register so they meet the carry in the same cycle. Finished low sum bits wait in alignment registers so that the whole sum and the final carry-out appear together.

With the default parameters the operands are 4 bits wide and are split into two 2-bit slices, giving a fixed latency of two clock cycles. A new operand pair may be presented on every clock, and a valid flag travels with each pair. The block has no stall input: whatever sits on the operand inputs at a rising edge enters the pipeline.

Top module: `psa_pipe_adder`

## Requirements
- R1: Two rising edges after operands `a_i` and `b_i` are sampled, `sum_o` equals (a_i + b_i) mod 16 and `cout_o` equals bit 4 of the 5-bit unsigned sum.
- R2: A new operand pair is accepted on every clock edge, and results leave back to back, one per cycle, in the order the pairs were presented.
- R3: `out_valid` equals the `in_valid` value sampled two rising edges earlier.
- R4: The carry out of operand bits 1..0 is held in a register and reaches the addition of bits 3..2 one cycle later, so a carry produced only in the low slice changes bit 2 and above of the result.
- R5: The result for a pair depends only on that pair; different operands presented in the following cycle do not alter it.
- R6: While `rst` is high at a rising edge, every pipeline register is cleared, so `sum_o`, `cout_o` and `out_valid` read 0 after that edge and the one that follows, and pairs in flight at that edge are lost.
- R7: The data path runs whether `in_valid` is 1 or 0: a pair presented with `in_valid` at 0 still produces its sum and carry two cycles later, with `out_valid` at 0.
- R8: The extreme cases are exact: 0 + 0 gives sum 0 with carry 0, 15 + 15 gives sum 14 with carry 1, and 15 + 1 gives sum 0 with carry 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers change on its rising edge |
| rst | input | 1 | Synchronous active-high reset of every pipeline register |
| in_valid | input | 1 | Marks the operand pair on `a_i`/`b_i` as meaningful |
| a_i | input | 4 | First unsigned operand |
| b_i | input | 4 | Second unsigned operand |
| out_valid | output | 1 | Valid flag delayed alongside the result |
| sum_o | output | 4 | Low four bits of the sum |
| cout_o | output | 1 | Carry out of the most significant bit |

## Verification
On every clock the checker compares the result and its valid flag against a delayed reference sum, confirms that the low-slice carry register holds the carry of the previous cycle's low bits, and confirms that a reset edge leaves the outputs at zero. What only the directed scenarios show is that results stay ordered and unmixed when operands change every cycle, that a reset in mid-stream drops exactly the pairs in flight, and that all 256 operand pairs come out right when streamed back to back.

// File: rtl/psa_pkg.sv
package psa_pkg;

    // Default slicing of the operands.
    localparam int unsigned DEF_SLICE_W    = 2;
    localparam int unsigned DEF_NUM_SLICES = 2;

    // Pipeline latency from operand sampling to result: one stage per slice.
    function automatic int unsigned pipe_latency(input int unsigned num_slices);
        return num_slices;
    endfunction

    // Extra alignment stages a slice's sum needs after its capture register.
    function automatic int unsigned align_depth(input int unsigned num_slices,
                                                input int unsigned slice_idx);
        return num_slices - 1 - slice_idx;
    endfunction

endpackage

// File: rtl/psa_slice_add.sv
module psa_slice_add #(
    parameter int unsigned W = 2
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         co
);

    logic [W:0] total;

    always_comb begin
        total = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
        s     = total[W-1:0];
        co    = total[W];
    end

endmodule

// File: rtl/psa_delay.sv
module psa_delay #(
    parameter int unsigned W     = 1,
    parameter int unsigned DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] stage_q [DEPTH];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
                end else begin
                    stage_q[0] <= d;
                    for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
                end
            end

            assign q = stage_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/psa_pipe_adder.sv
module psa_pipe_adder
    import psa_pkg::*;
#(
    parameter int unsigned SLICE_W    = DEF_SLICE_W,
    parameter int unsigned NUM_SLICES = DEF_NUM_SLICES,
    localparam int unsigned DATA_W    = SLICE_W * NUM_SLICES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              out_valid,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o
);

    localparam int unsigned LAT = pipe_latency(NUM_SLICES);

    // carry_q[k] is the registered carry into slice k; slice 0 takes zero.
    logic [NUM_SLICES:0] carry_q;
    assign carry_q[0] = 1'b0;

    generate
        for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
            localparam int unsigned LO = k * SLICE_W;

            logic [SLICE_W-1:0] op_a, op_b, part_sum, part_sum_q;
            logic               part_co;

            // Hold this slice's operand bits back k cycles to meet its carry.
            psa_delay #(.W(2*SLICE_W), .DEPTH(k)) u_skew (
                .clk (clk),
                .rst (rst),
                .d   ({a_i[LO +: SLICE_W], b_i[LO +: SLICE_W]}),
                .q   ({op_a, op_b})
            );

            psa_slice_add #(.W(SLICE_W)) u_add (
                .x   (op_a),
                .y   (op_b),
                .cin (carry_q[k]),
                .s   (part_sum),
                .co  (part_co)
            );

            // Capture this slice's sum bits and carry-out.
            psa_delay #(.W(SLICE_W + 1), .DEPTH(1)) u_cap (
                .clk (clk),
                .rst (rst),
                .d   ({part_co, part_sum}),
                .q   ({carry_q[k+1], part_sum_q})
            );

            // Align finished sum bits with the last slice.
            psa_delay #(.W(SLICE_W), .DEPTH(align_depth(NUM_SLICES, k))) u_align (
                .clk (clk),
                .rst (rst),
                .d   (part_sum_q),
                .q   (sum_o[LO +: SLICE_W])
            );
        end
    endgenerate

    assign cout_o = carry_q[NUM_SLICES];

    psa_delay #(.W(1), .DEPTH(LAT)) u_valid (
        .clk (clk),
        .rst (rst),
        .d   (in_valid),
        .q   (out_valid)
    );

endmodule

// File: rtl/psa_pipe_adder_chk.sv
module psa_pipe_adder_chk
    import psa_pkg::*;
#(
    parameter int unsigned SLICE_W    = DEF_SLICE_W,
    parameter int unsigned NUM_SLICES = DEF_NUM_SLICES,
    localparam int unsigned DATA_W    = SLICE_W * NUM_SLICES,
    localparam int unsigned LAT       = NUM_SLICES
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic              out_valid,
    input logic [DATA_W-1:0] sum_o,
    input logic              cout_o,
    input logic              low_carry
);

    // Reference: full-width sum and valid, delayed by the pipeline latency.
    logic [DATA_W:0] ref_q [LAT];
    logic [LAT-1:0]  vref_q;
    logic [SLICE_W:0] low_total;

    assign low_total = {1'b0, a_i[SLICE_W-1:0]} + {1'b0, b_i[SLICE_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LAT; i++) ref_q[i] <= '0;
            vref_q <= '0;
        end else begin
            ref_q[0]  <= {1'b0, a_i} + {1'b0, b_i};
            vref_q[0] <= in_valid;
            for (int i = 1; i < LAT; i++) begin
                ref_q[i]  <= ref_q[i-1];
                vref_q[i] <= vref_q[i-1];
            end
        end
    end

    // R1
    result_match_chk: assert property (@(posedge clk) disable iff (rst)
        {cout_o, sum_o} == ref_q[LAT-1]);

    // R3
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == vref_q[LAT-1]);

    // R4
    low_carry_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> low_carry == $past(low_total[SLICE_W]));

    // R6
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && sum_o == '0 && !cout_o));

endmodule

bind psa_pipe_adder psa_pipe_adder_chk #(
    .SLICE_W    (SLICE_W),
    .NUM_SLICES (NUM_SLICES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .a_i       (a_i),
    .b_i       (b_i),
    .out_valid (out_valid),
    .sum_o     (sum_o),
    .cout_o    (cout_o),
    .low_carry (carry_q[1])
);

// File: tb/psa_pipe_adder_bench.sv
module psa_pipe_adder_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [3:0] a_i = '0;
    logic [3:0] b_i = '0;
    logic       out_valid;
    logic [3:0] sum_o;
    logic       cout_o;

    int checks = 0;
    int errors = 0;

    // Expected {valid, cout, sum} for pairs driven one and two steps ago.
    logic [5:0] exp_1 = '0;
    logic [5:0] exp_2 = '0;
    bit         primed = 0;
    string      tag = "R6";

    always #(CLK_PERIOD/2) clk = ~clk;

    psa_pipe_adder u_psa_pipe_adder (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .a_i       (a_i),
        .b_i       (b_i),
        .out_valid (out_valid),
        .sum_o     (sum_o),
        .cout_o    (cout_o)
    );

    function automatic logic [5:0] expect_of(input logic [3:0] a, input logic [3:0] b,
                                             input logic v);
        logic [4:0] t;
        t = {1'b0, a} + {1'b0, b};
        return {v, t};
    endfunction

    // One clock step: check what the output shows now, then drive new inputs.
    task automatic step(input logic [3:0] a, input logic [3:0] b,
                        input logic v, input logic r);
        @(negedge clk);
        if (primed) begin
            checks++;
            if ({out_valid, cout_o, sum_o} !== exp_2) begin
                errors++;
                $display("FAIL %s got v=%b c=%b s=%h exp v=%b c=%b s=%h", tag,
                         out_valid, cout_o, sum_o, exp_2[5], exp_2[4], exp_2[3:0]);
            end
        end
        a_i = a; b_i = b; in_valid = v; rst = r;
        if (r) begin
            exp_1 = '0;
            exp_2 = '0;
            primed = 1;
        end else begin
            exp_2 = exp_1;
            exp_1 = expect_of(a, b, v);
        end
    endtask

    task automatic drain();
        step(4'h0, 4'h0, 1'b0, 1'b0);
        step(4'h0, 4'h0, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        tag = "R6";
        step(4'hF, 4'hF, 1'b1, 1'b1);
        step(4'hF, 4'hF, 1'b1, 1'b1);
        step(4'hF, 4'hF, 1'b1, 1'b1);
        drain();
    endtask

    task automatic t_carry();
        tag = "R4";
        step(4'h3, 4'h1, 1'b1, 1'b0);   // low carry makes bit 2
        step(4'h2, 4'h2, 1'b1, 1'b0);
        step(4'h1, 4'h3, 1'b1, 1'b0);
        step(4'h7, 4'h1, 1'b1, 1'b0);   // low carry ripples through high slice
        step(4'hD, 4'h3, 1'b1, 1'b0);   // low carry drives carry-out
        drain();
    endtask

    task automatic t_extremes();
        tag = "R8";
        step(4'h0, 4'h0, 1'b1, 1'b0);
        step(4'hF, 4'hF, 1'b1, 1'b0);
        step(4'hF, 4'h1, 1'b1, 1'b0);
        step(4'h8, 4'h8, 1'b1, 1'b0);
        drain();
    endtask

    task automatic t_skew();
        tag = "R5";
        step(4'h3, 4'h1, 1'b1, 1'b0);
        step(4'hC, 4'hC, 1'b1, 1'b0);
        step(4'h0, 4'h1, 1'b1, 1'b0);
        step(4'hF, 4'hE, 1'b1, 1'b0);
        step(4'h5, 4'hA, 1'b1, 1'b0);
        drain();
    endtask

    task automatic t_valid_gaps();
        tag = "R3";
        step(4'h1, 4'h2, 1'b1, 1'b0);
        step(4'h3, 4'h4, 1'b0, 1'b0);
        step(4'h5, 4'h6, 1'b1, 1'b0);
        step(4'h7, 4'h8, 1'b1, 1'b0);
        step(4'h9, 4'hA, 1'b0, 1'b0);
        drain();
    endtask

    task automatic t_idle_data();
        tag = "R7";
        step(4'hA, 4'h7, 1'b0, 1'b0);
        step(4'h6, 4'h6, 1'b0, 1'b0);
        step(4'hF, 4'h2, 1'b0, 1'b0);
        drain();
    endtask

    task automatic t_mid_reset();
        tag = "R6";
        step(4'h9, 4'h9, 1'b1, 1'b0);
        step(4'hB, 4'h4, 1'b1, 1'b0);
        step(4'hE, 4'h3, 1'b1, 1'b1);   // both pairs above are in flight
        step(4'h2, 4'h5, 1'b1, 1'b0);
        drain();
    endtask

    task automatic t_exhaustive();
        tag = "R1 R2";
        for (int i = 0; i < 256; i++) begin
            step(i[7:4], i[3:0], 1'b1, 1'b0);
        end
        drain();
    endtask

    initial begin
        t_reset();
        t_carry();
        t_extremes();
        t_skew();
        t_valid_gaps();
        t_idle_data();
        t_mid_reset();
        t_exhaustive();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule